// File: doc/BRIEF.md
# Two-Wire Debug Link Host Controller

This block is the host end of a two-wire serial debug link: a clock that the host generates and one shared data line. The link's data line is modelled as three plain pins: an output value, an output enable and the sensed level. A caller hands over one transaction at a time. Each transaction carries a port select (debug port or access port), a direction (read or write), a 2-bit register address and 32 bits of write data. The host serializes an 8-slot request header and releases the line for turnaround. It then samples a 3-slot acknowledge and, depending on that acknowledge and on the direction, sends or receives 32 data bits plus parity.

Commands enter on a valid/ready stream. A command is taken only while the engine is idle. `cmd_ready` drops at acceptance and stays low until the response for that command has been handed off, so a caller holding `cmd_valid` simply waits. The result leaves on a second valid/ready stream. Once `rsp_valid` rises, the response fields hold still until the cycle in which `rsp_ready` is also high. No new command is accepted before that cycle. Line reset, retries and multi-access sequencing belong to the caller.

One line-clock period is one bit slot. The line clock is low for the first half of each slot and high for the second. The host changes what it drives when the clock falls and samples the line when the clock rises. All fields travel least-significant bit first.

Top module: `sdbg_host`

## Requirements
- R1: Out of reset, and whenever no transaction or response is pending, `cmd_ready` is 1, `rsp_valid` is 0, `swclk` is low and `swdio_oe` is 0. A command is accepted only in a cycle where `cmd_valid` and `cmd_ready` are both 1. In the cycle after acceptance the host drives the start bit.
- R2: Each slot lasts 2*CLK_DIV core cycles: CLK_DIV cycles with `swclk` low, then CLK_DIV cycles with it high. Driven values change only while `swclk` is low. After the last slot of a transaction `swclk` stays low.
- R3: The header occupies 8 slots in this order: 1, `cmd_ap` (1 = access port), `cmd_rd` (1 = read), `cmd_addr[0]`, `cmd_addr[1]`, even parity (the XOR of the previous four), 0, and then a park slot in which `swdio_oe` is 0.
- R4: After the header, TURN_LEN slots follow in which the host does not drive the line.
- R5: The next 3 slots are sampled as the acknowledge. `rsp_ack[k]` is the k-th sampled slot. OK is 3'b001, WAIT is 3'b010 and FAULT is 3'b100.
- R6: On an OK write, the host drives 33 slots directly after the acknowledge: `cmd_wdata` LSB first, then the XOR of its 32 bits. The transaction ends there, with no turnaround.
- R7: On an OK read, the host releases the line for TURN_LEN slots, samples 33 slots, then releases the line for TURN_LEN slots. The first 32 sampled bits are returned on `rsp_rdata`, LSB first.
- R8: `rsp_perr` is 1 only on an OK read whose 33rd sampled bit differs from the XOR of the 32 data bits.
- R9: On WAIT or FAULT, TURN_LEN undriven slots follow the acknowledge and the transaction ends with no data phase. `rsp_rdata` is 0.
- R10: Any other acknowledge value sets `rsp_proto_err`. No slot follows the acknowledge: the line stays released and the clock stops low.
- R11: While `rsp_valid` is 1 and `rsp_ready` is 0, the response fields hold their values and `cmd_ready` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command will be taken |
| cmd_ap | input | 1 | 1 selects the access port, 0 the debug port |
| cmd_rd | input | 1 | 1 for a read, 0 for a write |
| cmd_addr | input | 2 | Register address bits |
| cmd_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Caller takes the response |
| rsp_ack | output | 3 | Sampled acknowledge, first slot in bit 0 |
| rsp_rdata | output | DATA_W | Read data (0 unless an OK read) |
| rsp_perr | output | 1 | Read data parity mismatch |
| rsp_proto_err | output | 1 | Acknowledge was not a defined code |
| swclk | output | 1 | Line clock |
| swdio_o | output | 1 | Data line value when driven |
| swdio_oe | output | 1 | Data line output enable |
| swdio_i | input | 1 | Sensed data line level |

## Verification
The bench builds the block with CLK_DIV=2 and TURN_LEN=2. A two-slot turnaround makes an off-by-one in any of the three release windows shift every following slot, and the bench checks each slot one by one. The short clock divider lets every acknowledge path, including a pull-up-only acknowledge of all ones, run in a few hundred core cycles. It also makes the high-phase and low-phase lengths directly countable.

// File: rtl/sdbg_pkg.sv
`timescale 1ns/1ps
package sdbg_pkg;

  // acknowledge codes, first sampled slot in bit 0
  localparam logic [2:0] ACK_OK    = 3'b001;
  localparam logic [2:0] ACK_WAIT  = 3'b010;
  localparam logic [2:0] ACK_FAULT = 3'b100;

  localparam int unsigned HDR_LEN = 8;
  localparam int unsigned ACK_LEN = 3;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_HDR,
    ST_TRN_A,
    ST_ACK,
    ST_TRN_B,
    ST_WDAT,
    ST_RDAT,
    ST_TRN_C,
    ST_RESP
  } seq_st_e;

endpackage

// File: rtl/sdbg_parity.sv
`timescale 1ns/1ps
module sdbg_parity #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] d,
  output logic         p
);
  assign p = ^d;
endmodule

// File: rtl/sdbg_clkgen.sv
`timescale 1ns/1ps
module sdbg_clkgen #(
  parameter int unsigned CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk,
  output logic rise_stb,
  output logic fall_stb
);
  localparam int unsigned CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap     = (cnt == LAST);
  assign rise_stb = run && wrap && !sclk;
  assign fall_stb = run && wrap && sclk;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (wrap) begin
      cnt  <= '0;
      sclk <= ~sclk;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/sdbg_seq.sv
`timescale 1ns/1ps
module sdbg_seq
  import sdbg_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned TURN_LEN = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              rise_stb,
  input  logic              fall_stb,
  output logic              run,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_ap,
  input  logic              cmd_rd,
  input  logic [1:0]        cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [2:0]        rsp_ack,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_perr,
  output logic              rsp_proto_err,
  output logic              swdio_o,
  output logic              swdio_oe,
  input  logic              swdio_i
);
  localparam int unsigned TXW = DATA_W + 1;
  localparam int unsigned M1  = (TXW > HDR_LEN) ? TXW : HDR_LEN;
  localparam int unsigned M2  = (M1 > TURN_LEN) ? M1 : TURN_LEN;
  localparam int unsigned BW  = $clog2(M2 + 1);

  seq_st_e         st, nxt;
  logic [BW-1:0]   bcnt, lim;
  logic [TXW-1:0]  tx;
  logic [TXW-1:0]  rx;
  logic [2:0]      ackq;
  logic            rd_q;
  logic [DATA_W-1:0] wdat_q;
  logic            hpar, wpar, rpar;
  logic [HDR_LEN-1:0] hdr;
  logic            ack_known;

  sdbg_parity #(.W(4)) u_hpar (
    .d ({cmd_addr, cmd_rd, cmd_ap}),
    .p (hpar)
  );
  sdbg_parity #(.W(DATA_W)) u_wpar (
    .d (wdat_q),
    .p (wpar)
  );
  sdbg_parity #(.W(DATA_W)) u_rpar (
    .d (rx[DATA_W-1:0]),
    .p (rpar)
  );

  // slot 7 (park) carries 1 but is never driven
  assign hdr = {1'b1, 1'b0, hpar, cmd_addr[1], cmd_addr[0], cmd_rd, cmd_ap, 1'b1};

  assign ack_known = (ackq == ACK_OK) || (ackq == ACK_WAIT) || (ackq == ACK_FAULT);

  always_comb begin
    case (st)
      ST_HDR:                     lim = BW'(HDR_LEN - 1);
      ST_TRN_A, ST_TRN_B, ST_TRN_C: lim = BW'(TURN_LEN - 1);
      ST_ACK:                     lim = BW'(ACK_LEN - 1);
      ST_WDAT, ST_RDAT:           lim = BW'(DATA_W);
      default:                    lim = '0;
    endcase
  end

  always_comb begin
    case (st)
      ST_HDR:   nxt = ST_TRN_A;
      ST_TRN_A: nxt = ST_ACK;
      ST_ACK: begin
        if (ackq == ACK_OK)                            nxt = rd_q ? ST_TRN_B : ST_WDAT;
        else if ((ackq == ACK_WAIT) || (ackq == ACK_FAULT)) nxt = ST_TRN_B;
        else                                           nxt = ST_RESP;
      end
      ST_TRN_B: nxt = (ackq == ACK_OK) ? ST_RDAT : ST_RESP;
      ST_RDAT:  nxt = ST_TRN_C;
      ST_WDAT:  nxt = ST_RESP;
      ST_TRN_C: nxt = ST_RESP;
      default:  nxt = st;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      bcnt   <= '0;
      tx     <= '0;
      rx     <= '0;
      ackq   <= '0;
      rd_q   <= 1'b0;
      wdat_q <= '0;
    end else begin
      if (rise_stb && (st == ST_ACK))  ackq <= {swdio_i, ackq[2:1]};
      if (rise_stb && (st == ST_RDAT)) rx   <= {swdio_i, rx[TXW-1:1]};
      case (st)
        ST_IDLE: begin
          if (cmd_valid) begin
            st     <= ST_HDR;
            bcnt   <= '0;
            tx     <= TXW'(hdr);
            rx     <= '0;
            ackq   <= '0;
            rd_q   <= cmd_rd;
            wdat_q <= cmd_wdata;
          end
        end
        ST_RESP: begin
          if (rsp_ready) st <= ST_IDLE;
        end
        default: begin
          if (fall_stb) begin
            if ((st == ST_HDR) || (st == ST_WDAT)) tx <= tx >> 1;
            if (bcnt == lim) begin
              bcnt <= '0;
              st   <= nxt;
              if (nxt == ST_WDAT) tx <= {wpar, wdat_q};
            end else begin
              bcnt <= bcnt + 1'b1;
            end
          end
        end
      endcase
    end
  end

  assign run           = (st != ST_IDLE) && (st != ST_RESP);
  assign cmd_ready     = (st == ST_IDLE);
  assign rsp_valid     = (st == ST_RESP);
  assign rsp_ack       = ackq;
  assign rsp_rdata     = rx[DATA_W-1:0];
  assign rsp_perr      = rd_q && (ackq == ACK_OK) && (rpar != rx[DATA_W]);
  assign rsp_proto_err = !ack_known;
  assign swdio_oe      = ((st == ST_HDR) && (bcnt != BW'(HDR_LEN - 1))) || (st == ST_WDAT);
  assign swdio_o       = swdio_oe & tx[0];

  // R2
  oe_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(swdio_oe) |-> !sclk);

  // R2
  data_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (swdio_oe && $past(swdio_oe) && !$stable(swdio_o)) |-> !sclk);

  // R1
  start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (swdio_oe && swdio_o && !cmd_ready));

  // R11
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && !cmd_ready && $stable(rsp_rdata) && $stable(rsp_ack)));

  // R10
  proto_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_proto_err) |-> (!rsp_perr && (rsp_rdata == '0) && !swdio_oe));

endmodule

// File: rtl/sdbg_host.sv
`timescale 1ns/1ps
module sdbg_host #(
  parameter int unsigned CLK_DIV  = 4,
  parameter int unsigned TURN_LEN = 1,
  parameter int unsigned DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_ap,
  input  logic              cmd_rd,
  input  logic [1:0]        cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [2:0]        rsp_ack,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_perr,
  output logic              rsp_proto_err,
  output logic              swclk,
  output logic              swdio_o,
  output logic              swdio_oe,
  input  logic              swdio_i
);
  logic run, rise_stb, fall_stb;

  sdbg_clkgen #(.CLK_DIV(CLK_DIV)) u_clkgen (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .sclk     (swclk),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  sdbg_seq #(.DATA_W(DATA_W), .TURN_LEN(TURN_LEN)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .sclk          (swclk),
    .rise_stb      (rise_stb),
    .fall_stb      (fall_stb),
    .run           (run),
    .cmd_valid     (cmd_valid),
    .cmd_ready     (cmd_ready),
    .cmd_ap        (cmd_ap),
    .cmd_rd        (cmd_rd),
    .cmd_addr      (cmd_addr),
    .cmd_wdata     (cmd_wdata),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_ack       (rsp_ack),
    .rsp_rdata     (rsp_rdata),
    .rsp_perr      (rsp_perr),
    .rsp_proto_err (rsp_proto_err),
    .swdio_o       (swdio_o),
    .swdio_oe      (swdio_oe),
    .swdio_i       (swdio_i)
  );

endmodule

// File: tb/sdbg_host_bench.sv
`timescale 1ns/1ps
module sdbg_host_bench;
  localparam int unsigned CLK_DIV  = 2;
  localparam int unsigned TURN_LEN = 2;
  localparam int unsigned DATA_W   = 32;

  typedef struct packed {
    logic        ap;
    logic        rd;
    logic [1:0]  addr;
    logic [31:0] wdata;
    logic [2:0]  ack;
    logic [31:0] rdata;
    logic        badpar;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 2'd1, 32'hA5A5_0F0F, 3'b001, 32'h0000_0000, 1'b0},
    '{1'b1, 1'b1, 2'd3, 32'h0000_0000, 3'b001, 32'h1BA0_1477, 1'b0},
    '{1'b1, 1'b0, 2'd0, 32'hDEAD_BEEF, 3'b010, 32'h0000_0000, 1'b0},
    '{1'b0, 1'b1, 2'd2, 32'h0000_0000, 3'b100, 32'h0000_0000, 1'b0},
    '{1'b0, 1'b1, 2'd0, 32'h0000_0000, 3'b001, 32'hFFFF_FFFF, 1'b1},
    '{1'b1, 1'b0, 2'd2, 32'h8000_0001, 3'b001, 32'h0000_0000, 1'b0},
    '{1'b1, 1'b1, 2'd1, 32'h0000_0000, 3'b111, 32'h0000_0000, 1'b0},
    '{1'b0, 1'b0, 2'd3, 32'h1234_5678, 3'b000, 32'h0000_0000, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic cmd_ap = 1'b0;
  logic cmd_rd = 1'b0;
  logic [1:0] cmd_addr = 2'd0;
  logic [DATA_W-1:0] cmd_wdata = '0;
  logic rsp_valid;
  logic rsp_ready = 1'b1;
  logic [2:0] rsp_ack;
  logic [DATA_W-1:0] rsp_rdata;
  logic rsp_perr, rsp_proto_err;
  logic swclk, swdio_o, swdio_oe, swdio_i;
  logic tgt_en = 1'b0;
  logic tgt_val = 1'b0;

  int n_chk = 0;
  int n_bad = 0;

  logic e_drv [64];
  logic e_val [64];
  logic t_en  [64];
  logic t_val [64];
  int   n_slot;

  always #2.5 clk = ~clk;

  // pull-up when nobody drives
  assign swdio_i = swdio_oe ? swdio_o : (tgt_en ? tgt_val : 1'b1);

  sdbg_host #(.CLK_DIV(CLK_DIV), .TURN_LEN(TURN_LEN), .DATA_W(DATA_W)) u_sdbg_host (
    .clk (clk), .rst_n (rst_n),
    .cmd_valid (cmd_valid), .cmd_ready (cmd_ready), .cmd_ap (cmd_ap), .cmd_rd (cmd_rd),
    .cmd_addr (cmd_addr), .cmd_wdata (cmd_wdata),
    .rsp_valid (rsp_valid), .rsp_ready (rsp_ready), .rsp_ack (rsp_ack), .rsp_rdata (rsp_rdata),
    .rsp_perr (rsp_perr), .rsp_proto_err (rsp_proto_err),
    .swclk (swclk), .swdio_o (swdio_o), .swdio_oe (swdio_oe), .swdio_i (swdio_i)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic add_slot(input logic drv, input logic val, input logic ten, input logic tv);
    e_drv[n_slot] = drv;
    e_val[n_slot] = val;
    t_en[n_slot]  = ten;
    t_val[n_slot] = tv;
    n_slot++;
  endtask

  task automatic send_cmd(input vec_t v);
    @(negedge clk);
    cmd_ap = v.ap; cmd_rd = v.rd; cmd_addr = v.addr; cmd_wdata = v.wdata;
    cmd_valid = 1'b1;
    @(posedge clk);
    #1 cmd_valid = 1'b0;
  endtask

  task automatic run_txn(input vec_t v, input bit hold);
    logic [7:0] hdr;
    logic hp;
    bit ok, known, got, seen_clk;
    int bad0, bad1, bad2;
    string tail_tag, end_tag;
    logic exp_perr;
    logic [31:0] exp_rd;
    hp  = v.ap ^ v.rd ^ v.addr[0] ^ v.addr[1];
    hdr = {1'b1, 1'b0, hp, v.addr[1], v.addr[0], v.rd, v.ap, 1'b1};
    ok    = (v.ack == 3'b001);
    known = ok || (v.ack == 3'b010) || (v.ack == 3'b100);
    n_slot = 0;
    for (int i = 0; i < 8; i++) add_slot(i != 7, hdr[i], 1'b0, 1'b0);
    for (int i = 0; i < int'(TURN_LEN); i++) add_slot(1'b0, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) add_slot(1'b0, 1'b0, 1'b1, v.ack[i]);
    if (ok && !v.rd) begin
      tail_tag = "R6";
      for (int i = 0; i < 32; i++) add_slot(1'b1, v.wdata[i], 1'b0, 1'b0);
      add_slot(1'b1, ^v.wdata, 1'b0, 1'b0);
    end else if (ok) begin
      tail_tag = "R7";
      for (int i = 0; i < int'(TURN_LEN); i++) add_slot(1'b0, 1'b0, 1'b0, 1'b0);
      for (int i = 0; i < 32; i++) add_slot(1'b0, 1'b0, 1'b1, v.rdata[i]);
      add_slot(1'b0, 1'b0, 1'b1, (^v.rdata) ^ v.badpar);
      for (int i = 0; i < int'(TURN_LEN); i++) add_slot(1'b0, 1'b0, 1'b0, 1'b0);
    end else if (known) begin
      tail_tag = "R9";
      for (int i = 0; i < int'(TURN_LEN); i++) add_slot(1'b0, 1'b0, 1'b0, 1'b0);
    end else begin
      tail_tag = "R10";
    end
    end_tag = known ? "R2" : "R10";
    rsp_ready = !hold;
    send_cmd(v);
    bad0 = 0; bad1 = 0; bad2 = 0;
    for (int k = 0; k < n_slot; k++) begin
      tgt_en  = t_en[k];
      tgt_val = t_val[k];
      @(posedge swclk);
      #1;
      if ((swdio_oe !== e_drv[k]) || (e_drv[k] && (swdio_o !== e_val[k]))) begin
        if (k < 8) bad0++;
        else if (k < 8 + int'(TURN_LEN)) bad1++;
        else bad2++;
      end
    end
    tgt_en = 1'b0;
    chk(bad0 == 0, "R3", "header slot mismatches", bad0, 0);
    chk(bad1 == 0, "R4", "turnaround slot mismatches", bad1, 0);
    chk(bad2 == 0, tail_tag, "ack/data slot mismatches", bad2, 0);
    @(negedge swclk);
    got = 0; seen_clk = 0;
    for (int w = 0; w < 40 && !got; w++) begin
      @(negedge clk);
      if (swclk) seen_clk = 1;
      if (rsp_valid) got = 1;
    end
    chk(got && !seen_clk, end_tag, "response raised, no extra clock", {30'd0, got, seen_clk}, 32'd2);
    exp_perr = ok && v.rd && v.badpar;
    exp_rd   = (ok && v.rd) ? v.rdata : 32'd0;
    chk(rsp_ack === v.ack, "R5", "rsp_ack", {29'd0, rsp_ack}, {29'd0, v.ack});
    if (!(ok && !v.rd))
      chk(rsp_rdata === exp_rd, ok ? "R7" : (known ? "R9" : "R10"), "rsp_rdata", rsp_rdata, exp_rd);
    chk(rsp_perr === exp_perr, "R8", "rsp_perr", {31'd0, rsp_perr}, {31'd0, exp_perr});
    chk(rsp_proto_err === !known, "R10", "rsp_proto_err", {31'd0, rsp_proto_err}, {31'd0, !known});
    if (hold) begin
      cmd_ap = 1'b0; cmd_rd = 1'b0; cmd_addr = 2'd0; cmd_wdata = 32'h5555_5555;
      cmd_valid = 1'b1;
      repeat (6) @(negedge clk);
      chk(rsp_valid && !cmd_ready && (rsp_rdata === exp_rd) && (rsp_ack === v.ack),
          "R11", "held response / blocked command", {30'd0, rsp_valid, cmd_ready}, 32'd2);
      cmd_valid = 1'b0;
      rsp_ready = 1'b1;
      @(negedge clk);
      chk(!rsp_valid && cmd_ready, "R11", "release after ready",
          {30'd0, rsp_valid, cmd_ready}, 32'd1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int cyc;
    vec_t d;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cmd_ready && !rsp_valid && !swclk && !swdio_oe, "R1", "idle outputs after reset",
        {28'd0, cmd_ready, rsp_valid, swclk, swdio_oe}, 32'h8);

    for (int i = 0; i < NV; i++) run_txn(VECS[i], 1'b0);

    // R2 clock phase lengths; line left to the pull-up gives ack 111 (R10)
    d = '{1'b0, 1'b1, 2'd0, 32'h0, 3'b111, 32'h0, 1'b0};
    tgt_en = 1'b0;
    send_cmd(d);
    cyc = 0;
    do begin @(posedge clk); #1; cyc++; end while (!swclk && cyc < 50);
    chk(cyc == int'(CLK_DIV), "R2", "low phase core cycles", cyc, CLK_DIV);
    cyc = 0;
    do begin @(posedge clk); #1; cyc++; end while (swclk && cyc < 50);
    chk(cyc == int'(CLK_DIV), "R2", "high phase core cycles", cyc, CLK_DIV);
    cyc = 0;
    while (!rsp_valid && cyc < 500) begin @(negedge clk); cyc++; end
    chk(rsp_valid && rsp_proto_err && !swdio_oe, "R10", "pull-up ack gives protocol error",
        {29'd0, rsp_valid, rsp_proto_err, swdio_oe}, 32'h6);
    @(negedge clk);

    // R11 back-pressure on an OK read
    run_txn('{1'b1, 1'b1, 2'd2, 32'h0, 3'b001, 32'hC3C3_3C3C, 1'b0}, 1'b1);

    repeat (4) @(negedge clk);
    chk(cmd_ready && !rsp_valid && !swclk && !swdio_oe, "R1", "idle outputs after traffic",
        {28'd0, cmd_ready, rsp_valid, swclk, swdio_oe}, 32'h8);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule